// File: doc/BRIEF.md
# Trace Synchronization Period Counter

This block watches the stream of bytes that a trace unit produces and raises a single-cycle synchronization request every time a programmed number of bytes has gone by. The number is programmed as a 5-bit power-of-two exponent. Exponents from 8 through 20 give periods from 256 bytes up to 1 MiB. A code of zero turns periodic requests off. Every other code is reserved, and this design handles a reserved code by producing no requests.

Each cycle the trace unit reports how many bytes it emitted, from 0 to 8. The block adds that figure to a running total. When the total reaches or passes the period, the block pulses the request and keeps the excess as the opening count of the next period, so that no byte is lost. The period is held in the low five bits of a 64-bit register. A write to it is honoured only while the trace unit reports that it is idle. The byte count is held at zero for as long as the unit is idle, so every trace session starts a fresh period.

Top module: `tsync_period_ctr`

## Requirements
- R1: The readback word carries the stored period code in bits 4:0, and bits 63:5 always read as zero.
- R2: A write is accepted only in a cycle where `unit_idle` is high. An accepted write stores `wr_data[4:0]`, and the new code shows on the readback from the cycle after the write edge. A write made while `unit_idle` is low leaves the stored code unchanged.
- R3: With code 0, `sync_req` never asserts, whatever bytes arrive.
- R4: With a code N from 8 to 20, `sync_req` asserts once for each 2^N bytes counted. The pulse appears in the cycle after the cycle whose byte count made the total reach or pass 2^N.
- R5: Codes 1 to 7 and 21 to 31 are reserved. They are stored and read back like any other code, but they produce no requests.
- R6: `sync_req` is high for exactly one cycle per crossing. The bytes beyond the threshold are carried into the next period.
- R7: After reset the stored code is 0, the byte total is 0 and `sync_req` is low.
- R8: While `unit_idle` is high, the byte total is cleared and `bytes_in` is ignored. An accepted write also clears the total, so each busy period after idle starts counting from zero.
- R9: `bytes_in` values above 8 are counted as 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bytes_in | input | 4 | Trace bytes emitted this cycle (0 to 8) |
| unit_idle | input | 1 | High while the trace unit is idle |
| wr_en | input | 1 | Period register write strobe |
| wr_data | input | 64 | Period register write data; only bits 4:0 are stored |
| rd_data | output | 64 | Period register readback |
| sync_req | output | 1 | One-cycle synchronization request |

## Verification
The readback is taken straight from the code register, so an accepted write is visible one edge after it is made. `sync_req` is registered, so it rises one edge after the cycle in which its byte count was presented. The bench drives each input two nanoseconds after a rising edge and samples the outputs at the same point after the next edge. It compares `sync_req` cycle by cycle against a running byte total of its own, which wraps at 2^N. Each stream is also checked against a hand-computed pulse total, including one full 2^20-byte period at eight bytes per cycle.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  localparam int TS_REG_W     = 64;
  localparam int TS_CODE_W    = 5;
  localparam int TS_CNT_W     = 21;
  localparam int TS_BYTES_W   = 4;
  localparam int TS_MIN_CODE  = 8;
  localparam int TS_MAX_CODE  = 20;
  localparam int TS_MAX_BYTES = 8;
endpackage

// File: rtl/tsync_period_reg.sv
module tsync_period_reg #(
  parameter int REG_W  = tsync_pkg::TS_REG_W,
  parameter int CODE_W = tsync_pkg::TS_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              unit_idle,
  input  logic [REG_W-1:0]  wr_data,
  output logic [CODE_W-1:0] code_q,
  output logic              wr_accept,
  output logic [REG_W-1:0]  rd_data
);
  localparam int PAD_W = REG_W - CODE_W;

  // writes land only while the unit is quiet
  assign wr_accept = wr_en & unit_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= '0;
    else if (wr_accept) code_q <= wr_data[CODE_W-1:0];
  end

  assign rd_data = {{PAD_W{1'b0}}, code_q};
endmodule

// File: rtl/tsync_code_decode.sv
module tsync_code_decode #(
  parameter int CODE_W   = tsync_pkg::TS_CODE_W,
  parameter int CNT_W    = tsync_pkg::TS_CNT_W,
  parameter int MIN_CODE = tsync_pkg::TS_MIN_CODE,
  parameter int MAX_CODE = tsync_pkg::TS_MAX_CODE
) (
  input  logic [CODE_W-1:0] code,
  output logic              code_ok,
  output logic [CNT_W-1:0]  limit
);
  localparam int NCODES = 1 << CODE_W;

  logic [NCODES-1:0] legal_map;

  for (genvar g = 0; g < NCODES; g++) begin : g_map
    assign legal_map[g] = (g >= MIN_CODE) && (g <= MAX_CODE);
  end

  function automatic logic [CNT_W-1:0] limit_of(input logic [CODE_W-1:0] c);
    logic [CNT_W-1:0] one;
    one = {{(CNT_W-1){1'b0}}, 1'b1};
    return one << c;
  endfunction

  assign code_ok = legal_map[code];
  assign limit   = code_ok ? limit_of(code) : '0;
endmodule

// File: rtl/tsync_byte_accum.sv
module tsync_byte_accum #(
  parameter int CNT_W     = tsync_pkg::TS_CNT_W,
  parameter int BYTES_W   = tsync_pkg::TS_BYTES_W,
  parameter int MAX_BYTES = tsync_pkg::TS_MAX_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               enable,
  input  logic [BYTES_W-1:0] bytes_in,
  input  logic [CNT_W-1:0]   limit,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               crossed,
  output logic               req_q
);
  function automatic logic [BYTES_W-1:0] clamp_bytes(input logic [BYTES_W-1:0] b);
    logic [BYTES_W-1:0] top;
    top = BYTES_W'(MAX_BYTES);
    return (b > top) ? top : b;
  endfunction

  logic [CNT_W-1:0] sum;

  assign sum     = cnt_q + CNT_W'(clamp_bytes(bytes_in));
  assign crossed = enable && !clear && (sum >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= crossed;
      if (clear)        cnt_q <= '0;
      else if (crossed) cnt_q <= sum - limit;   // keep the overshoot
      else if (enable)  cnt_q <= sum;
    end
  end
endmodule

// File: rtl/tsync_period_ctr.sv
module tsync_period_ctr #(
  parameter int REG_W     = tsync_pkg::TS_REG_W,
  parameter int CODE_W    = tsync_pkg::TS_CODE_W,
  parameter int CNT_W     = tsync_pkg::TS_CNT_W,
  parameter int BYTES_W   = tsync_pkg::TS_BYTES_W,
  parameter int MIN_CODE  = tsync_pkg::TS_MIN_CODE,
  parameter int MAX_CODE  = tsync_pkg::TS_MAX_CODE,
  parameter int MAX_BYTES = tsync_pkg::TS_MAX_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BYTES_W-1:0] bytes_in,
  input  logic               unit_idle,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic               sync_req
);
  logic [CODE_W-1:0] code_q;
  logic              wr_accept;
  logic              code_ok;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  cnt_q;
  logic              crossed;
  logic              cnt_clear;
  logic              cnt_run;

  tsync_period_reg #(.REG_W(REG_W), .CODE_W(CODE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .unit_idle(unit_idle),
    .wr_data(wr_data), .code_q(code_q), .wr_accept(wr_accept), .rd_data(rd_data)
  );

  tsync_code_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W),
                      .MIN_CODE(MIN_CODE), .MAX_CODE(MAX_CODE)) u_dec (
    .code(code_q), .code_ok(code_ok), .limit(limit)
  );

  assign cnt_clear = unit_idle | wr_accept;
  assign cnt_run   = code_ok & ~unit_idle;

  tsync_byte_accum #(.CNT_W(CNT_W), .BYTES_W(BYTES_W), .MAX_BYTES(MAX_BYTES)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .enable(cnt_run),
    .bytes_in(bytes_in), .limit(limit), .cnt_q(cnt_q), .crossed(crossed), .req_q(sync_req)
  );
endmodule

// File: rtl/tsync_period_chk.sv
module tsync_period_chk #(
  parameter int REG_W  = tsync_pkg::TS_REG_W,
  parameter int CODE_W = tsync_pkg::TS_CODE_W,
  parameter int CNT_W  = tsync_pkg::TS_CNT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             unit_idle,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             sync_req,
  input logic             code_ok,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] limit
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:CODE_W] == '0);

  assert_busy_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_idle |=> rd_data[CODE_W-1:0] == $past(rd_data[CODE_W-1:0]));

  assert_idle_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unit_idle) |=> rd_data[CODE_W-1:0] == $past(wr_data[CODE_W-1:0]));

  // R3 and R5: disabled or reserved code never yields a request
  assert_no_req_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok |=> !sync_req);

  assert_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> !sync_req);

  assert_count_below_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok |-> cnt_q < limit);

  assert_idle_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unit_idle |=> (cnt_q == '0) && !sync_req);
endmodule

bind tsync_period_ctr tsync_period_chk #(.REG_W(REG_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .unit_idle(unit_idle), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .sync_req(sync_req), .code_ok(code_ok), .cnt_q(cnt_q), .limit(limit)
);

// File: tb/sim_tsync_period_ctr.sv
`timescale 1ns/1ps
module sim_tsync_period_ctr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bytes_in;
  logic        unit_idle;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [63:0] rd_data;
  logic        sync_req;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int cur_code = 0;
  longint acc = 0;

  always #4 clk = ~clk;   // 125 MHz

  tsync_period_ctr u0 (
    .clk(clk), .rst_n(rst_n), .bytes_in(bytes_in), .unit_idle(unit_idle),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sync_req(sync_req)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance one edge; inputs are driven and outputs sampled 2 ns after the edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic longint period_of(input int code);
    if (code >= 8 && code <= 20) return longint'(1) << code;
    return 0;
  endfunction

  task automatic program_code(input longint data);
    unit_idle = 1'b1; wr_en = 1'b1; wr_data = data; bytes_in = 4'd8;
    step();
    wr_en = 1'b0; wr_data = '0;
    cur_code = int'(data[4:0]);
    acc = 0;
  endtask

  // mode 0: constant value cval; mode 1: i mod 9
  task automatic run_stream(input int n, input int mode, input int cval,
                            input string req, input int exp_pulses);
    longint lim;
    int pulses;
    int mism;
    lim = period_of(cur_code);
    pulses = 0; mism = 0;
    unit_idle = 1'b0;
    for (int i = 0; i < n; i++) begin
      int b;
      bit exp;
      b = (mode == 0) ? cval : (i % 9);
      bytes_in = 4'(b);
      step();
      if (b > 8) b = 8;
      exp = 1'b0;
      if (lim != 0) begin
        acc += b;
        if (acc >= lim) begin exp = 1'b1; acc -= lim; end
      end
      if (sync_req) pulses++;
      if (sync_req !== exp) begin
        if (mism == 0) $display("FAIL %s cycle %0d sync_req actual=%0d expected=%0d", req, i, sync_req, exp);
        mism++;
      end
    end
    bytes_in = '0;
    checks++;
    if (mism != 0) failures++;
    check(pulses == exp_pulses, req, pulses, exp_pulses);
  endtask

  task automatic t_reset();
    check(rd_data == 64'd0, "R7 readback after reset", rd_data, 0);
    check(sync_req == 1'b0, "R7 request after reset", sync_req, 0);
  endtask

  task automatic t_readback();
    program_code(64'hFFFF_FFFF_FFFF_FFFF);
    check(rd_data == 64'h1F, "R1 upper bits zero", rd_data, 64'h1F);
  endtask

  task automatic t_gate();
    unit_idle = 1'b0; wr_en = 1'b1; wr_data = 64'd9;
    step();
    wr_en = 1'b0;
    check(rd_data == 64'h1F, "R2 busy write ignored", rd_data, 64'h1F);
    program_code(64'd12);
    check(rd_data == 64'd12, "R2 idle write accepted", rd_data, 12);
  endtask

  task automatic t_disabled();
    program_code(64'd0);
    run_stream(300, 0, 8, "R3 code zero disabled", 0);
  endtask

  task automatic t_period8();
    program_code(64'd8);
    run_stream(96, 0, 8, "R4 period 256", 3);
  endtask

  task automatic t_overshoot();
    program_code(64'd8);
    run_stream(200, 0, 7, "R6 overshoot carry", 5);
  endtask

  task automatic t_mixed();
    program_code(64'd9);
    run_stream(300, 1, 0, "R4 mixed bytes period 512", 2);
  endtask

  task automatic t_reserved();
    program_code(64'd5);
    run_stream(300, 0, 8, "R5 reserved low code", 0);
    program_code(64'd21);
    check(rd_data == 64'd21, "R5 reserved code readback", rd_data, 21);
    run_stream(300, 0, 8, "R5 reserved high code", 0);
  endtask

  task automatic t_idle_clear();
    program_code(64'd8);
    run_stream(25, 0, 8, "R8 partial period", 0);
    unit_idle = 1'b1; bytes_in = 4'd8;
    step();
    check(sync_req == 1'b0, "R8 no request while idle", sync_req, 0);
    acc = 0;
    run_stream(32, 0, 8, "R8 count restarts after idle", 1);
  endtask

  task automatic t_clamp();
    program_code(64'd8);
    run_stream(64, 0, 15, "R9 oversize byte count", 2);
  endtask

  task automatic t_max();
    program_code(64'd20);
    run_stream(131072, 0, 8, "R4 period 2^20", 1);
  endtask

  initial begin
    rst_n = 1'b0; bytes_in = '0; unit_idle = 1'b1; wr_en = 1'b0; wr_data = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_readback();
    t_gate();
    t_disabled();
    t_period8();
    t_overshoot();
    t_mixed();
    t_reserved();
    t_idle_clear();
    t_clamp();
    t_max();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule